// File: doc/BRIEF.md
# Configurable Sample Bit Packer

This block takes signed receive samples from interleaved channels (I and Q, for example) and makes each one narrower. First a run-time left shift moves the wanted bits of the sample into position. The result is then rounded and saturated to 1, 2, 4, 8 or 16 bits. The narrowed samples are packed, least significant slot first, into 16-bit words for a host transfer FIFO. A narrower sample width gives proportionally fewer output words for the same input rate. Gain control, filtering and the host bus are handled elsewhere.

Samples arrive on a valid/ready stream that carries a channel index. Words leave on a valid/ready stream. The output holds a single word register. While that word is waiting and `out_ready` is low, `in_ready` is low, so back-pressure passes straight to the sample source and no sample is lost.

Configuration is loaded with a one-cycle write strobe. Every write also throws away any partly filled word and restarts packing at channel 0, so each channel keeps its slot in every word.

Top module: `sample_packer`

## Requirements
- R1: On a write, `cfg_width` selects the sample width: codes 0, 1, 2, 3 and 4 give 1, 2, 4, 8 and 16 bits. Codes 5 to 7 are stored as code 4 (16 bits).
- R2: The input sample is sign-extended and shifted left by `cfg_shift` (0 to 15). The result for width W is the shifted value divided by 2^(16-W) and rounded. No wrap happens inside the shifter.
- R3: With `cfg_round_even`=0, an exact tie rounds upward (towards +infinity). With 1, it rounds to the even neighbour. Other remainders round to the nearest value in both modes.
- R4: A rounded value outside the signed W-bit range is clamped to 2^(W-1)-1 or to -2^(W-1). It never wraps.
- R5: At width 1, the slot holds 1 when the shifted sample is negative and 0 otherwise.
- R6: Samples fill a word from bit 0 upward in acceptance order, each in W two's-complement bits. A word appears on `out_data` with `out_valid` only once exactly 16 bits are filled.
- R7: A sample is packed only if `in_chan` equals the expected channel. The expected channel starts at 0 and counts 0..NUM_CH-1 cyclically per packed sample. Other accepted samples are discarded and leave the word unchanged.
- R8: A `cfg_wr` cycle loads the configuration, discards the partial word, resets the expected channel to 0 and holds `in_ready` low. A word already on the output is kept.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` stays unchanged and `in_ready` is low.
- R10: After reset, `out_valid` is 0, `in_ready` is 1, and the configuration is width 16, shift 0, upward tie rounding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Sample accepted when high together with in_valid |
| in_data | input | SAMPLE_W (16) | Signed input sample |
| in_chan | input | CH_W (1) | Channel index of the sample |
| cfg_wr | input | 1 | Configuration write strobe, also flushes |
| cfg_width | input | 3 | Width code (R1) |
| cfg_shift | input | SHIFT_W (4) | Left shift amount |
| cfg_round_even | input | 1 | 1 selects ties-to-even rounding |
| out_valid | output | 1 | Packed word present |
| out_ready | input | 1 | Word taken when high together with out_valid |
| out_data | output | WORD_W (16) | Packed word |

## Verification
The hardest case to reach is a configuration write that lands while a word is half built, because the output must show no trace of the discarded samples. The stimulus leaves one sample in an 8-bit word, rewrites the configuration, and then sends a full pair. It checks that exactly one word appears and that it holds only the new pair. Out-of-order channel indices are reached the same way: samples with a deliberately wrong index sit between good ones, and the bench confirms that the slot order does not change.

// File: rtl/packer_pkg.sv
package packer_pkg;
  typedef enum logic {
    RND_HALF_UP = 1'b0,
    RND_EVEN    = 1'b1
  } round_mode_e;
endpackage

// File: rtl/pk_cfg_regs.sv
module pk_cfg_regs
  import packer_pkg::*;
#(
  parameter int CODE_W     = 3,
  parameter int SHIFT_W    = 4,
  parameter int NUM_WIDTHS = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [CODE_W-1:0]  width_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic               even_i,
  output logic [CODE_W-1:0]  width_q,
  output logic [SHIFT_W-1:0] shift_q,
  output round_mode_e        mode_q
);
  localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(NUM_WIDTHS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      width_q <= MAX_CODE;
      shift_q <= '0;
      mode_q  <= RND_HALF_UP;
    end else if (wr) begin
      width_q <= (width_i > MAX_CODE) ? MAX_CODE : width_i;
      shift_q <= shift_i;
      mode_q  <= even_i ? RND_EVEN : RND_HALF_UP;
    end
  end
endmodule

// File: rtl/pk_reduce.sv
module pk_reduce
  import packer_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int WORD_W     = 16,
  parameter int SHIFT_W    = 4,
  parameter int CODE_W     = 3,
  parameter int NUM_WIDTHS = 5,
  parameter int FILL_W     = 5
) (
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [SHIFT_W-1:0]  shift,
  input  logic [CODE_W-1:0]   code,
  input  round_mode_e         mode,
  output logic [WORD_W-1:0]   slot_val,
  output logic [FILL_W-1:0]   slot_bits
);
  localparam int X_W = 2 * SAMPLE_W + 2;

  logic signed [X_W-1:0] shifted;
  logic [WORD_W-1:0]     cand [NUM_WIDTHS];

  assign shifted = $signed({{(X_W-SAMPLE_W){sample[SAMPLE_W-1]}}, sample}) <<< shift;

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
    localparam int W = 1 << g;
    localparam int K = SAMPLE_W - W;
    if (g == 0) begin : g_sign
      assign cand[g] = WORD_W'(shifted[X_W-1]);
    end else begin : g_multi
      logic signed [X_W-1:0] q;
      logic [X_W-W:0]        hi;
      logic                  fits;
      logic [W-1:0]          res;
      if (K == 0) begin : g_exact
        assign q = shifted;
      end else begin : g_round
        localparam logic [K-1:0] HALF = K'(1) << (K - 1);
        logic signed [X_W-1:0] fl;
        logic [K-1:0]          rem;
        logic                  up;
        assign fl  = shifted >>> K;
        assign rem = shifted[K-1:0];
        assign up  = (mode == RND_EVEN) ? ((rem > HALF) || ((rem == HALF) && fl[0]))
                                        : (rem >= HALF);
        assign q   = fl + X_W'(up);
      end
      assign hi   = q[X_W-1:W-1];
      assign fits = (&hi) | ~(|hi);
      assign res  = fits ? q[W-1:0]
                  : (q[X_W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}});
      assign cand[g] = WORD_W'(res);
    end
  end

  always_comb begin
    slot_val = cand[NUM_WIDTHS-1];
    for (int i = 0; i < NUM_WIDTHS; i++)
      if (code == CODE_W'(i)) slot_val = cand[i];
  end

  assign slot_bits = FILL_W'(1) << code;
endmodule

// File: rtl/pk_word_fill.sv
module pk_word_fill #(
  parameter int WORD_W = 16,
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1,
  parameter int FILL_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              fire,
  input  logic [CH_W-1:0]   chan,
  input  logic [WORD_W-1:0] slot_val,
  input  logic [FILL_W-1:0] slot_bits,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data
);
  localparam logic [CH_W-1:0]   LAST_CH = CH_W'(NUM_CH - 1);
  localparam logic [FILL_W-1:0] FULL    = FILL_W'(WORD_W);

  logic [CH_W-1:0]   exp_ch;
  logic [FILL_W-1:0] fill;
  logic [WORD_W-1:0] acc;
  logic              take;
  logic [WORD_W-1:0] merged;
  logic [FILL_W-1:0] fill_nxt;

  assign take     = fire && (chan == exp_ch);
  assign merged   = acc | (slot_val << fill);
  assign fill_nxt = fill + slot_bits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_ch    <= '0;
      fill      <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (flush) begin
        exp_ch <= '0;
        fill   <= '0;
        acc    <= '0;
      end else if (take) begin
        exp_ch <= (exp_ch == LAST_CH) ? '0 : exp_ch + 1'b1;
        if (fill_nxt == FULL) begin
          out_data  <= merged;
          out_valid <= 1'b1;
          acc       <= '0;
          fill      <= '0;
        end else begin
          acc  <= merged;
          fill <= fill_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/sample_packer.sv
module sample_packer
  import packer_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int WORD_W   = 16,
  parameter int NUM_CH   = 2,
  parameter int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  parameter int SHIFT_W  = $clog2(SAMPLE_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_data,
  input  logic [CH_W-1:0]     in_chan,
  input  logic                cfg_wr,
  input  logic [2:0]          cfg_width,
  input  logic [SHIFT_W-1:0]  cfg_shift,
  input  logic                cfg_round_even,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [WORD_W-1:0]   out_data
);
  localparam int NUM_WIDTHS = $clog2(WORD_W) + 1;
  localparam int CODE_W     = 3;
  localparam int FILL_W     = $clog2(WORD_W) + 1;

  logic [CODE_W-1:0]  width_q;
  logic [SHIFT_W-1:0] shift_q;
  round_mode_e        mode_q;
  logic [WORD_W-1:0]  slot_val;
  logic [FILL_W-1:0]  slot_bits;
  logic               fire;

  assign in_ready = (!out_valid || out_ready) && !cfg_wr;
  assign fire     = in_valid && in_ready;

  pk_cfg_regs #(
    .CODE_W(CODE_W), .SHIFT_W(SHIFT_W), .NUM_WIDTHS(NUM_WIDTHS)
  ) i_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr),
    .width_i(cfg_width), .shift_i(cfg_shift), .even_i(cfg_round_even),
    .width_q(width_q), .shift_q(shift_q), .mode_q(mode_q)
  );

  pk_reduce #(
    .SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W), .SHIFT_W(SHIFT_W),
    .CODE_W(CODE_W), .NUM_WIDTHS(NUM_WIDTHS), .FILL_W(FILL_W)
  ) i_reduce (
    .sample(in_data), .shift(shift_q), .code(width_q), .mode(mode_q),
    .slot_val(slot_val), .slot_bits(slot_bits)
  );

  pk_word_fill #(
    .WORD_W(WORD_W), .NUM_CH(NUM_CH), .CH_W(CH_W), .FILL_W(FILL_W)
  ) i_fill (
    .clk(clk), .rst_n(rst_n), .flush(cfg_wr), .fire(fire), .chan(in_chan),
    .slot_val(slot_val), .slot_bits(slot_bits), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/sample_packer_chk.sv
module sample_packer_chk #(
  parameter int SAMPLE_W = 16,
  parameter int WORD_W   = 16,
  parameter int CH_W     = 1,
  parameter int SHIFT_W  = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [SAMPLE_W-1:0] in_data,
  input logic [CH_W-1:0]     in_chan,
  input logic                cfg_wr,
  input logic [2:0]          cfg_width,
  input logic [SHIFT_W-1:0]  cfg_shift,
  input logic                cfg_round_even,
  input logic                out_valid,
  input logic                out_ready,
  input logic [WORD_W-1:0]   out_data
);
  a_r9_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r9_stall_input: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> !(in_valid && in_ready) || out_ready);

  a_r6_word_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  a_r6_drain_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !(in_valid && in_ready)) |=> !out_valid);

  a_r8_flush_no_word: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !$rose(out_valid));

  a_r8_cfg_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |-> !(in_valid && in_ready));
endmodule

bind sample_packer sample_packer_chk #(
  .SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W), .CH_W(CH_W), .SHIFT_W(SHIFT_W)
) i_chk (.*);

// File: tb/test_sample_packer.sv
module test_sample_packer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic [0:0]  in_chan = '0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_width = 3'd4;
  logic [3:0]  cfg_shift = '0;
  logic        cfg_round_even = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;

  int checks = 0;
  int errors = 0;
  logic [15:0] got_q[$];
  logic [15:0] exp_q[$];
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  sample_packer i_sample_packer (.*);

  always @(negedge clk) begin
    #2;
    if (rst_n && out_valid && out_ready) got_q.push_back(out_data);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int wbits(input logic [2:0] code);
    return (code > 3'd4) ? 16 : (1 << code);
  endfunction

  function automatic logic [15:0] ref_q(input logic [15:0] d, input logic [3:0] sh,
                                        input logic [2:0] code, input bit rne);
    longint x, fl, rem, half, q, hi, lo;
    int w, k;
    w = wbits(code);
    x = longint'($signed(d)) * (longint'(1) << sh);
    if (w == 1) return (x < 0) ? 16'd1 : 16'd0;
    k = 16 - w;
    fl = x >>> k;
    rem = x - (fl << k);
    q = fl;
    if (k > 0) begin
      half = longint'(1) << (k - 1);
      if (rem > half || (rem == half && (!rne || fl[0]))) q = fl + 1;
    end
    hi = (longint'(1) << (w - 1)) - 1;
    lo = -(longint'(1) << (w - 1));
    if (q > hi) q = hi;
    if (q < lo) q = lo;
    return 16'(q & ((longint'(1) << w) - 1));
  endfunction

  task automatic cfg(input logic [2:0] code, input logic [3:0] sh, input bit rne,
                     input bit chk_ready);
    @(negedge clk);
    cfg_width = code; cfg_shift = sh; cfg_round_even = rne; cfg_wr = 1'b1;
    #1;
    if (chk_ready) chk(in_ready == 1'b0, "R8", "in_ready during cfg write", {15'd0, in_ready}, 16'd0);
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic send(input logic ch, input logic [15:0] d);
    in_chan = ch; in_data = d; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_words(input string req);
    repeat (4) @(negedge clk);
    #3;
    chk(got_q.size() == exp_q.size(), req, "word count", 16'(got_q.size()), 16'(exp_q.size()));
    while (got_q.size() > 0 && exp_q.size() > 0) begin
      logic [15:0] g, e;
      g = got_q.pop_front();
      e = exp_q.pop_front();
      chk(g == e, req, "packed word", g, e);
    end
    got_q.delete();
    exp_q.delete();
  endtask

  function automatic logic [15:0] next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R10", "out_valid after reset", {15'd0, out_valid}, 16'd0);
    chk(in_ready == 1'b1, "R10", "in_ready after reset", {15'd0, in_ready}, 16'd1);
    send(1'b0, 16'hBEEF);
    exp_q.push_back(16'hBEEF);
    check_words("R10");
  endtask

  task automatic t_sweep(input logic [2:0] code, input logic [3:0] sh, input bit rne);
    int w, n, fill;
    logic [15:0] acc;
    cfg(code, sh, rne, 1'b0);
    w = wbits(code);
    n = 2 * (16 / w);
    fill = 0;
    acc = '0;
    for (int i = 0; i < n; i++) begin
      logic [15:0] d;
      d = next_rand();
      if (i % 3 == 0) d = 16'($signed(d) >>> 5);
      send(1'(i % 2), d);
      acc = acc | (ref_q(d, sh, code, rne) << fill);
      fill += w;
      if (fill == 16) begin
        exp_q.push_back(acc);
        acc = '0;
        fill = 0;
      end
    end
    check_words("R1 R2 R6");
  endtask

  task automatic t_rounding();
    cfg(3'd3, 4'd0, 1'b0, 1'b0);
    send(1'b0, 16'h0080); send(1'b1, 16'hFF80);
    send(1'b0, 16'h0180); send(1'b1, 16'hFE80);
    exp_q.push_back(16'h0001); exp_q.push_back(16'hFF02);
    check_words("R3 half-up");
    cfg(3'd3, 4'd0, 1'b1, 1'b0);
    send(1'b0, 16'h0080); send(1'b1, 16'hFF80);
    send(1'b0, 16'h0180); send(1'b1, 16'hFE80);
    exp_q.push_back(16'h0000); exp_q.push_back(16'hFE02);
    check_words("R3 even");
  endtask

  task automatic t_saturate();
    cfg(3'd3, 4'd4, 1'b0, 1'b0);
    send(1'b0, 16'h7FF0); send(1'b1, 16'h8000);
    exp_q.push_back(16'h807F);
    check_words("R4 shifted");
    cfg(3'd3, 4'd0, 1'b0, 1'b0);
    send(1'b0, 16'h7FFF); send(1'b1, 16'h8080);
    exp_q.push_back(16'h817F);
    check_words("R4 round-up");
  endtask

  task automatic t_sign();
    logic [15:0] pat;
    pat = 16'hA5C3;
    cfg(3'd0, 4'd0, 1'b0, 1'b0);
    for (int i = 0; i < 16; i++)
      send(1'(i % 2), pat[i] ? (16'h8000 | 16'(i)) : (16'h0001 + 16'(i)));
    exp_q.push_back(pat);
    check_words("R5");
  endtask

  task automatic t_channel();
    cfg(3'd3, 4'd0, 1'b0, 1'b0);
    send(1'b1, 16'h1100);
    send(1'b0, 16'h2200);
    send(1'b0, 16'h3300);
    send(1'b1, 16'h4400);
    exp_q.push_back(16'h4422);
    check_words("R7");
  endtask

  task automatic t_flush();
    cfg(3'd3, 4'd0, 1'b0, 1'b0);
    send(1'b0, 16'h5500);
    cfg(3'd3, 4'd0, 1'b0, 1'b1);
    send(1'b0, 16'h6600);
    send(1'b1, 16'h7700);
    exp_q.push_back(16'h7766);
    check_words("R8");
  endtask

  task automatic t_backpressure();
    cfg(3'd4, 4'd0, 1'b0, 1'b0);
    out_ready = 1'b0;
    send(1'b0, 16'h1234);
    in_chan = 1'b1; in_data = 16'h5678; in_valid = 1'b1;
    #1;
    chk(out_valid == 1'b1, "R9", "out_valid while stalled", {15'd0, out_valid}, 16'd1);
    chk(in_ready == 1'b0, "R9", "in_ready while stalled", {15'd0, in_ready}, 16'd0);
    repeat (3) @(negedge clk);
    #1;
    chk(out_data == 16'h1234, "R9", "held word", out_data, 16'h1234);
    chk(in_ready == 1'b0, "R9", "in_ready still low", {15'd0, in_ready}, 16'd0);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    exp_q.push_back(16'h1234);
    exp_q.push_back(16'h5678);
    check_words("R9");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sweep(3'd0, 4'd0, 1'b0);
    t_sweep(3'd1, 4'd2, 1'b0);
    t_sweep(3'd2, 4'd1, 1'b1);
    t_sweep(3'd3, 4'd3, 1'b1);
    t_sweep(3'd4, 4'd0, 1'b0);
    t_sweep(3'd6, 4'd1, 1'b0);
    t_rounding();
    t_saturate();
    t_sign();
    t_channel();
    t_flush();
    t_backpressure();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule